// File: doc/BRIEF.md
# Debug Command Register Behind a JTAG TAP

This block is the instruction-side command register of an on-chip debug unit. It sits behind a JTAG TAP controller and takes the controller's state strobes as inputs. During an IR scan it shifts in a 10-bit command word. It latches that word when the TAP passes update-IR. The word carries a read flag, a go (single-step or resume) flag, an exit flag and a 7-bit register-select code.

The register-select code does not act at update-IR. Instead, it routes the next DR scan to one of fifteen debug data registers through a sparse decode map. The selected register's value is loaded at capture-DR and shifted out on TDO. Write data is shifted in at the same time and is committed only when the TAP passes update-DR. Codes that select nothing, including the dedicated bypass code, place a one-bit bypass stage between TDI and TDO.

The go and exit actions also wait for update-DR, even when no data register stands behind the selected code. The registers themselves live outside this block. The block receives their read values and emits one write-enable per register, the shared write data, and the go, exit and read indications.

Top module: `dbg_cmd_reg`

## Requirements
- R1: After reset the latched command has the read, go and exit flags clear and selects the identification register (code 0x02). All write enables, go_o and exit_o are low, and rd_mode_o is low.
- R2: The command is held in a 10-bit value v. In v, bits 6:0 are the select code, bit 7 is exit, bit 8 is go and bit 9 is read. Bits of v are shifted in on tdi_i during shift-IR with v[0] first. Capture-IR loads the currently latched command, and that command appears on tdo_o with bit 0 first. The latched command changes only in the cycle in which update_ir_i is high.
- R3: Capture-DR loads the selected register's read value. Each shift-DR cycle then presents that value on tdo_o, least significant bit first.
- R4: When update_dr_i is high and the read flag is 0, exactly one write enable rises in the following cycle for one cycle. It belongs to the selected writable register. wr_data_o then holds the last shifted-in bits: the low 32 bits for a word register, or the low SCAN_W bits for the CPU scan register.
- R5: With the read flag at 1, update-DR produces no write enable.
- R6: The identification register (slot 0) and the PC FIFO register (slot 9) never receive a write enable.
- R7: The bypass code 0x11 and every code outside the map form a one-bit path. The first TDO bit after capture is 0, and each later bit is the TDI bit shifted in one cycle earlier. Update-DR produces no write enable.
- R8: go_o pulses high for one cycle after an update-DR cycle when the latched go flag is 1, whatever code is selected. It stays low otherwise.
- R9: exit_o pulses high for one cycle after an update-DR cycle when the latched exit flag is 1, whatever code is selected. It stays low otherwise.
- R10: Code 0x10 selects the CPU scan register (slot 14), whose scan length is SCAN_W bits. Every other mapped register is 32 bits long.
- R11: tdo_o changes only on the falling edge of tck_i.
- R12: The decode map sends each code to a slot and write-enable bit as follows. 0x02 goes to slot 0 (identification, read-only). 0x12 goes to slot 1 (debug control). 0x20 to 0x23 go to slots 2 to 5 (instruction compares). 0x24 and 0x25 go to slots 6 and 7 (data compares). 0x2C goes to slot 8 (counter). 0x2D goes to slot 9 (PC FIFO, read-only). 0x30 goes to slot 10 (status). 0x31 to 0x33 go to slots 11 to 13 (control 0 to 2). Slot k of word_rd_i occupies bits 32k+31:32k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_ir_i | input | 1 | TAP is in capture-IR |
| shift_ir_i | input | 1 | TAP is in shift-IR |
| update_ir_i | input | 1 | TAP is in update-IR |
| capture_dr_i | input | 1 | TAP is in capture-DR |
| shift_dr_i | input | 1 | TAP is in shift-DR |
| update_dr_i | input | 1 | TAP is in update-DR |
| tdi_i | input | 1 | Serial test data in |
| word_rd_i | input | 14*REG_W | Read values of the 32-bit registers, slot k at bits k*REG_W and up |
| scan_rd_i | input | SCAN_W | Read value of the CPU scan register |
| tdo_o | output | 1 | Serial test data out, updated on the falling edge |
| wr_en_o | output | 15 | One-cycle write enable per slot |
| wr_data_o | output | max(SCAN_W,REG_W) | Write data for the strobed register |
| go_o | output | 1 | One-cycle go pulse |
| exit_o | output | 1 | One-cycle exit pulse |
| rd_mode_o | output | 1 | Latched read flag |

## Verification
Assertions check four things on every cycle. The latched command never moves outside update-IR. At most one write enable is high at a time. The identification and PC FIFO slots are never strobed. Write enables, go and exit appear only in the cycle after update-DR, and only with the proper flags and a mapped code.

Other behaviour only the bench's scenarios can show. These are the data values seen on TDO, the bit order and the one-cycle bypass delay. They also include the width of the scan-register path and the data presented with each write. Finally, they include the fact that an IR scan which never reaches update-IR leaves the earlier selection in force.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int CMD_W     = 10;
  localparam int RS_W      = 7;
  localparam int NUM_SLOTS = 15;
  localparam int NUM_WORD  = NUM_SLOTS - 1;

  typedef enum logic [3:0] {
    SL_IDCODE = 4'd0,
    SL_CTRL   = 4'd1,
    SL_IAC0   = 4'd2,
    SL_IAC1   = 4'd3,
    SL_IAC2   = 4'd4,
    SL_IAC3   = 4'd5,
    SL_DAC0   = 4'd6,
    SL_DAC1   = 4'd7,
    SL_CNT    = 4'd8,
    SL_PCQ    = 4'd9,
    SL_STAT   = 4'd10,
    SL_DCTL0  = 4'd11,
    SL_DCTL1  = 4'd12,
    SL_DCTL2  = 4'd13,
    SL_SCAN   = 4'd14
  } slot_e;

  typedef struct packed {
    logic            rd;
    logic            go;
    logic            ex;
    logic [RS_W-1:0] rs;
  } cmd_t;

  localparam cmd_t CMD_RST = '{rd: 1'b0, go: 1'b0, ex: 1'b0, rs: 7'h02};
endpackage

// File: rtl/dbg_ir_stage.sv
module dbg_ir_stage
  import dbg_cmd_pkg::*;
(
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic tdi_i,
  output logic ir_lsb_o,
  output cmd_t cmd_o
);
  logic [CMD_W-1:0] sh_q;
  cmd_t             cmd_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cmd_q <= CMD_RST;
    end else begin
      if (capture_i)    sh_q <= cmd_q;
      else if (shift_i) sh_q <= {tdi_i, sh_q[CMD_W-1:1]};
      if (update_i)     cmd_q <= cmd_t'(sh_q);
    end
  end

  assign ir_lsb_o = sh_q[0];
  assign cmd_o    = cmd_q;

  // R2
  cmd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$past(update_i) |-> $stable(cmd_q));
endmodule

// File: rtl/dbg_rs_decode.sv
module dbg_rs_decode
  import dbg_cmd_pkg::*;
(
  input  logic [RS_W-1:0] rs_i,
  output logic            hit_o,
  output slot_e           slot_o,
  output logic            ro_o,
  output logic            long_o
);
  always_comb begin
    hit_o  = 1'b1;
    slot_o = SL_IDCODE;
    unique case (rs_i)
      7'h02:   slot_o = SL_IDCODE;
      7'h10:   slot_o = SL_SCAN;
      7'h12:   slot_o = SL_CTRL;
      7'h20:   slot_o = SL_IAC0;
      7'h21:   slot_o = SL_IAC1;
      7'h22:   slot_o = SL_IAC2;
      7'h23:   slot_o = SL_IAC3;
      7'h24:   slot_o = SL_DAC0;
      7'h25:   slot_o = SL_DAC1;
      7'h2C:   slot_o = SL_CNT;
      7'h2D:   slot_o = SL_PCQ;
      7'h30:   slot_o = SL_STAT;
      7'h31:   slot_o = SL_DCTL0;
      7'h32:   slot_o = SL_DCTL1;
      7'h33:   slot_o = SL_DCTL2;
      default: hit_o  = 1'b0; // bypass code and reserved codes
    endcase
  end

  assign ro_o   = (slot_o == SL_IDCODE) || (slot_o == SL_PCQ);
  assign long_o = hit_o && (slot_o == SL_SCAN);
endmodule

// File: rtl/dbg_dr_path.sv
module dbg_dr_path #(
  parameter int REG_W  = 32,
  parameter int SCAN_W = 64,
  localparam int DR_W  = (SCAN_W > REG_W) ? SCAN_W : REG_W
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            long_i,
  input  logic            tdi_i,
  input  logic [DR_W-1:0] cap_val_i,
  output logic [DR_W-1:0] dr_o,
  output logic            byp_o
);
  logic [DR_W-1:0] sh_q, sh_nxt;
  logic            byp_q;

  // TDI enters at the top of the selected chain length
  for (genvar g = 0; g < DR_W; g++) begin : g_bit
    if (g == DR_W - 1) begin : g_top
      assign sh_nxt[g] = tdi_i;
    end else if (g == REG_W - 1) begin : g_tap
      assign sh_nxt[g] = long_i ? sh_q[g+1] : tdi_i;
    end else begin : g_mid
      assign sh_nxt[g] = sh_q[g+1];
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      byp_q <= 1'b0;
    end else if (capture_i) begin
      sh_q  <= cap_val_i;
      byp_q <= 1'b0;
    end else if (shift_i) begin
      sh_q  <= sh_nxt;
      byp_q <= tdi_i;
    end
  end

  assign dr_o  = sh_q;
  assign byp_o = byp_q;
endmodule

// File: rtl/dbg_cmd_reg.sv
module dbg_cmd_reg
  import dbg_cmd_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int SCAN_W = 64,
  localparam int DR_W  = (SCAN_W > REG_W) ? SCAN_W : REG_W
) (
  input  logic                     tck_i,
  input  logic                     rst_ni,
  input  logic                     capture_ir_i,
  input  logic                     shift_ir_i,
  input  logic                     update_ir_i,
  input  logic                     capture_dr_i,
  input  logic                     shift_dr_i,
  input  logic                     update_dr_i,
  input  logic                     tdi_i,
  input  logic [NUM_WORD*REG_W-1:0] word_rd_i,
  input  logic [SCAN_W-1:0]        scan_rd_i,
  output logic                     tdo_o,
  output logic [NUM_SLOTS-1:0]     wr_en_o,
  output logic [DR_W-1:0]          wr_data_o,
  output logic                     go_o,
  output logic                     exit_o,
  output logic                     rd_mode_o
);
  cmd_t            cmd;
  logic            ir_lsb;
  logic            sel_hit, sel_ro, sel_long;
  slot_e           sel_slot;
  logic [3:0]      word_idx;
  logic [DR_W-1:0] cap_val, dr_q;
  logic            byp_q;
  logic [NUM_SLOTS-1:0] wr_d, wr_q;
  logic            go_q, exit_q, ir_path_q, tdo_q, tdo_d;

  dbg_ir_stage u_ir (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_ir_i),
    .shift_i   (shift_ir_i),
    .update_i  (update_ir_i),
    .tdi_i     (tdi_i),
    .ir_lsb_o  (ir_lsb),
    .cmd_o     (cmd)
  );

  dbg_rs_decode u_dec (
    .rs_i   (cmd.rs),
    .hit_o  (sel_hit),
    .slot_o (sel_slot),
    .ro_o   (sel_ro),
    .long_o (sel_long)
  );

  assign word_idx = (sel_slot < SL_SCAN) ? sel_slot : 4'd0;

  always_comb begin
    cap_val = '0;
    if (sel_long) cap_val[SCAN_W-1:0] = scan_rd_i;
    else          cap_val[REG_W-1:0]  = word_rd_i[int'(word_idx)*REG_W +: REG_W];
  end

  dbg_dr_path #(.REG_W(REG_W), .SCAN_W(SCAN_W)) u_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_dr_i),
    .shift_i   (shift_dr_i),
    .long_i    (sel_long),
    .tdi_i     (tdi_i),
    .cap_val_i (cap_val),
    .dr_o      (dr_q),
    .byp_o     (byp_q)
  );

  always_comb begin
    wr_d = '0;
    if (update_dr_i && !cmd.rd && sel_hit && !sel_ro) wr_d[sel_slot] = 1'b1;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= '0;
      go_q      <= 1'b0;
      exit_q    <= 1'b0;
      ir_path_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      go_q   <= update_dr_i && cmd.go;
      exit_q <= update_dr_i && cmd.ex;
      if (capture_ir_i)      ir_path_q <= 1'b1;
      else if (capture_dr_i) ir_path_q <= 1'b0;
    end
  end

  assign tdo_d = ir_path_q ? ir_lsb : (sel_hit ? dr_q[0] : byp_q);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else         tdo_q <= tdo_d;
  end

  assign tdo_o     = tdo_q;
  assign wr_en_o   = wr_q;
  assign wr_data_o = dr_q;
  assign go_o      = go_q;
  assign exit_o    = exit_q;
  assign rd_mode_o = cmd.rd;

  // R4
  wr_onehot_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  // R5
  rd_no_wr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $past(update_dr_i) && $past(rd_mode_o) |-> wr_en_o == '0);
  // R6
  ro_no_wr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !wr_en_o[SL_IDCODE] && !wr_en_o[SL_PCQ]);
  // R7
  byp_no_wr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $past(update_dr_i) && !$past(sel_hit) |-> wr_en_o == '0);
  // R8
  go_src_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    go_o |-> $past(update_dr_i) && $past(cmd.go));
  // R9
  exit_src_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    exit_o |-> $past(update_dr_i) && $past(cmd.ex));
endmodule

// File: tb/dbg_cmd_reg_bench.sv
module dbg_cmd_reg_bench;
  localparam int REG_W  = 32;
  localparam int SCAN_W = 64;
  localparam int NSL    = 15;

  typedef struct packed {
    logic [6:0]  rs;
    logic        rd;
    logic        go;
    logic        ex;
    logic [31:0] din;
    logic [3:0]  slot;  // 15 = none
    logic        wr;
  } vec_t;

  localparam vec_t VEC [18] = '{
    '{7'h12, 1'b0, 1'b0, 1'b0, 32'h1111_2222,  4'd1, 1'b1},
    '{7'h20, 1'b0, 1'b1, 1'b0, 32'hDEAD_0001,  4'd2, 1'b1},
    '{7'h21, 1'b0, 1'b0, 1'b0, 32'h0BAD_F00D,  4'd3, 1'b1},
    '{7'h22, 1'b0, 1'b0, 1'b0, 32'h3C3C_C3C3,  4'd4, 1'b1},
    '{7'h23, 1'b1, 1'b0, 1'b0, 32'h0000_FFFF,  4'd5, 1'b0},
    '{7'h24, 1'b0, 1'b0, 1'b0, 32'h6666_9999,  4'd6, 1'b1},
    '{7'h25, 1'b0, 1'b0, 1'b1, 32'h8000_0001,  4'd7, 1'b1},
    '{7'h2C, 1'b0, 1'b0, 1'b0, 32'h1234_5678,  4'd8, 1'b1},
    '{7'h2D, 1'b0, 1'b0, 1'b0, 32'hAAAA_5555,  4'd9, 1'b0},
    '{7'h02, 1'b0, 1'b0, 1'b0, 32'h5555_AAAA,  4'd0, 1'b0},
    '{7'h30, 1'b0, 1'b0, 1'b0, 32'h0F0F_F0F0, 4'd10, 1'b1},
    '{7'h31, 1'b1, 1'b1, 1'b0, 32'h7777_0000, 4'd11, 1'b0},
    '{7'h32, 1'b0, 1'b0, 1'b0, 32'h4242_2424, 4'd12, 1'b1},
    '{7'h33, 1'b0, 1'b1, 1'b1, 32'hCAFE_BABE, 4'd13, 1'b1},
    '{7'h11, 1'b0, 1'b1, 1'b0, 32'h9ABC_DEF0, 4'd15, 1'b0},
    '{7'h7F, 1'b0, 1'b0, 1'b1, 32'h1357_9BDF, 4'd15, 1'b0},
    '{7'h13, 1'b0, 1'b0, 1'b0, 32'h2468_ACE0, 4'd15, 1'b0},
    '{7'h00, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 4'd15, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cir = 0, sir = 0, uir = 0, cdr = 0, sdr = 0, udr = 0, tdi = 0;
  logic [14*REG_W-1:0] word_rd;
  logic [SCAN_W-1:0]   scan_rd = 64'h0123_4567_89AB_CDEF;
  logic tdo, go, ex, rdm;
  logic [NSL-1:0]      wr_en;
  logic [SCAN_W-1:0]   wr_data;

  int compared = 0, mismatched = 0, rise_chg = 0;
  logic tdo_pre;

  always #10 clk = ~clk;

  dbg_cmd_reg #(.REG_W(REG_W), .SCAN_W(SCAN_W)) u_dbg_cmd_reg (
    .tck_i(clk), .rst_ni(rst_n),
    .capture_ir_i(cir), .shift_ir_i(sir), .update_ir_i(uir),
    .capture_dr_i(cdr), .shift_dr_i(sdr), .update_dr_i(udr),
    .tdi_i(tdi), .word_rd_i(word_rd), .scan_rd_i(scan_rd),
    .tdo_o(tdo), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .go_o(go), .exit_o(ex), .rd_mode_o(rdm)
  );

  function automatic logic [31:0] wv(input int k);
    return {8'hC0 + 8'(k), 8'h5A, 8'(k), 8'h3C};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c_ir, s_ir, u_ir, c_dr, s_dr, u_dr, d);
    @(negedge clk); #1;
    cir = c_ir; sir = s_ir; uir = u_ir; cdr = c_dr; sdr = s_dr; udr = u_dr; tdi = d;
    #7 tdo_pre = tdo;
    @(posedge clk); #1;
    if (tdo !== tdo_pre) rise_chg++;
  endtask

  task automatic ir_scan(input logic [9:0] v, input logic upd, output logic [9:0] cap);
    cyc(1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 10; k++) begin
      cyc(0, 1, 0, 0, 0, 0, v[k]);
      cap[k] = tdo_pre;
    end
    if (upd) cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  // after return: pulse outputs valid; pw/pg/pe hold them, q* hold next cycle
  logic [NSL-1:0] pw, qw;
  logic [63:0]    pd;
  logic           pg, pe, qg, qe;

  task automatic dr_scan(input logic [63:0] din, input int len, output logic [63:0] dout);
    dout = '0;
    cyc(0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < len; k++) begin
      cyc(0, 0, 0, 0, 1, 0, din[k]);
      dout[k] = tdo_pre;
    end
    cyc(0, 0, 0, 0, 0, 1, 0);
    pw = wr_en; pd = wr_data; pg = go; pe = ex;
    cyc(0, 0, 0, 0, 0, 0, 0);
    qw = wr_en; qg = go; qe = ex;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [9:0]  cap;
    logic [63:0] dout, exp_rb;
    for (int k = 0; k < 14; k++) word_rd[k*32 +: 32] = wv(k);
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 reset outputs", {rdm, go, ex, wr_en}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1 default selection reads ID; R6 write to ID suppressed
    dr_scan(64'hFFFF_FFFF, 32, dout);
    chk("R1 reset selects ID", dout[31:0], wv(0));
    chk("R6 ID write suppressed", pw, '0);

    // R2 capture-IR returns reset command
    ir_scan({3'b000, 7'h12}, 1'b1, cap);
    chk("R2 IR capture of reset command", cap, 10'h002);
    // R2 capture returns latched command, bit order
    ir_scan({3'b100, 7'h24}, 1'b1, cap);
    chk("R2 IR capture of latched command", cap, {3'b000, 7'h12});
    chk("R2 read flag latched", rdm, 1'b1);
    // R2 no update-IR: selection unchanged (still 0x24 read)
    ir_scan({3'b000, 7'h30}, 1'b0, cap);
    dr_scan(64'h0, 32, dout);
    chk("R2 selection kept without update-IR", dout[31:0], wv(6));
    chk("R2 rd flag kept without update-IR", pw, '0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R12
    foreach (VEC[i]) begin
      ir_scan({VEC[i].rd, VEC[i].go, VEC[i].ex, VEC[i].rs}, 1'b1, cap);
      chk("R2 rd_mode_o", rdm, VEC[i].rd);
      dr_scan({32'h0, VEC[i].din}, 32, dout);
      exp_rb = (VEC[i].slot == 4'd15) ? {32'h0, VEC[i].din[30:0], 1'b0}
                                      : {32'h0, wv(int'(VEC[i].slot))};
      chk(VEC[i].slot == 4'd15 ? "R7 bypass TDO" : "R3 R12 readback", dout, exp_rb);
      chk("R4 R5 R6 R7 write enable", pw, VEC[i].wr ? (15'(1) << VEC[i].slot) : 15'(0));
      if (VEC[i].wr) chk("R4 write data", pd[31:0], VEC[i].din);
      chk("R8 go pulse", pg, VEC[i].go);
      chk("R9 exit pulse", pe, VEC[i].ex);
      chk("R4 R8 R9 single cycle", {qw, qg, qe}, '0);
    end

    // R10 scan register: 64-bit chain read and write
    ir_scan({3'b000, 7'h10}, 1'b1, cap);
    dr_scan(64'hFEDC_BA98_7654_3210, 64, dout);
    chk("R10 scan readback", dout, scan_rd);
    chk("R10 scan write enable", pw, 15'(1) << 14);
    chk("R10 scan write data", pd, 64'hFEDC_BA98_7654_3210);

    // R5 read of scan register: no strobe
    ir_scan({3'b100, 7'h10}, 1'b1, cap);
    dr_scan(64'h5, 64, dout);
    chk("R5 read scan no strobe", pw, '0);

    // R8 R9 no pulse without update-DR (update-IR with flags set only)
    ir_scan({3'b011, 7'h11}, 1'b1, cap);
    chk("R8 R9 no pulse at update-IR", {go, ex}, 2'b00);
    dr_scan(64'h0, 3, dout);
    chk("R8 R9 pulse at update-DR on bypass", {pg, pe}, 2'b11);

    // R11
    chk("R11 TDO moved on rising edge", rise_chg, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule